// File: doc/BRIEF.md
# Transmit Frame Timing Front End

This block sets the bit-level timing of the transmit side of a DS3/E3 framer. It runs on the transmit clock pin and keeps a frame position counter. From that position it knows whether each bit time carries payload or overhead. The counter works in one of two framings. The DS3 framing has 4760 bits: 56 blocks, each one overhead bit followed by 84 payload bits. The E3 framing has 1536 bits, and its first 12 bits are overhead.

The frame-boundary pin has two directions. As an output, it marks the last bit of every frame. As an input, it realigns the counter. The payload qualifier pin has three possible forms. It can be a steady enable level, or a clock that is gapped during overhead. An override input forces it to carry the free-running clock. An 8-bit configuration register sets the frame-pin direction and the qualifier form. It also inverts each interface pin one by one, including the clock pin.

Software loads the register through a write strobe and can read it back. The downstream overhead inserter and data path take their timing from the qualifier pin, the overhead-enable pin and the frame pin.

Top module: `tx_frame_timer`

## Requirements
- R1: While reset is held and after it is released, the configuration reads 0 and the frame pin is an input (`sof_pin_oe`=0). The counter sits at bit 0, which is overhead, so `qual_pin`=0 and `ohen_pin`=1.
- R2: A write strobe sampled on a rising clock-pin edge loads `cfg_wdata` into the register, and `cfg_rdata` returns it. The bit meanings are as follows. bit0 inverts the qualifier pin, bit1 inverts the data pin, bit2 inverts the clock pin, bit3 inverts the frame pin and bit4 inverts the overhead data pin. bit5 inverts the overhead-enable pin. bit6 drives the frame pin out when 1. bit7 selects the gapped-clock qualifier when 1.
- R3: With `e3_sel`=0 the frame repeats every 4760 cycles. Bit p is overhead exactly when p mod 85 equals 0.
- R4: With `e3_sel`=1 the frame repeats every 1536 cycles, and bits 0 to 11 are overhead.
- R5: With bit6=1, `sof_pin_oe` is 1 and the frame pin is active for exactly the last bit time of each frame.
- R6: With bit6=0, an active level on the frame input, sampled at a clock edge, puts the counter on the last bit. The next bit time is then bit 0. Activity is judged after the bit3 polarity correction.
- R7: The overhead-enable level is the complement of the payload qualifier level, and the two change on the same edge.
- R8: With bit7=1, the qualifier pin is low while the clock is low. In the high phase that starts at the edge ending bit b, it is high exactly when bit b is payload.
- R9: When `clk_force`=1, the qualifier pin carries the core clock whatever bit7 holds. Bit0 still applies to it.
- R10: Each invert bit, when 1, inverts its pin: qualifier, data, frame, overhead data and overhead enable. When 0, the pin passes unchanged.
- R11: With bit2=1, all frame timing advances on the falling edge of the clock pin.
- R12: With bit6=1, activity on the frame input has no effect on the frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Transmit clock pin |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read-back |
| clk_force | input | 1 | Clock-control override for the qualifier |
| e3_sel | input | 1 | 0 selects DS3 framing, 1 selects E3 framing |
| sof_pin_in | input | 1 | Frame pin, input side |
| sof_pin_out | output | 1 | Frame pin, output side |
| sof_pin_oe | output | 1 | Frame pin output enable |
| data_pin | input | 1 | Transmit data pin |
| data_core | output | 1 | Polarity-corrected data |
| oh_pin | input | 1 | Overhead data pin |
| oh_core | output | 1 | Polarity-corrected overhead data |
| ohen_pin | output | 1 | Overhead enable pin |
| qual_pin | output | 1 | Payload qualifier pin (level or gapped clock) |

## Verification
The bench checks whole frames in both framings, one position at a time. A counter that wraps one bit early or late, or that puts the overhead bit at the wrong offset inside a block, gives a mismatch at a known position. The bench realigns the counter mid-frame through the input pin at both polarities. A design that realigned to bit 0 instead of the last bit would then be out by one cycle. One that ignored the polarity correction would never realign. A pulse on the frame input while the pin is an output catches a design that still obeys it. The gapped clock is sampled in both clock phases. A gate taken from the wrong cycle would show pulses shifted by one bit. An override with the wrong priority would leave the clock gapped. Clock inversion is checked by the phase of the clock pin at each frame-pin edge.

// File: rtl/tft_pkg.sv
`timescale 1ns/1ps
package tft_pkg;

    // Configuration register layout, most significant field first, so
    // qual_inv occupies bit 0 and qmode bit 7.
    typedef struct packed {
        logic qmode;     // 1: gapped clock on the qualifier pin
        logic sof_dir;   // 1: frame pin is an output
        logic ohen_inv;
        logic oh_inv;
        logic sof_inv;
        logic clk_inv;
        logic data_inv;
        logic qual_inv;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/tft_cfg_reg.sv
`timescale 1ns/1ps
module tft_cfg_reg
    import tft_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic we_i,
    input  cfg_t wdata_i,
    output cfg_t cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R2: a write lands in the register on the next edge
    a_r2_cfg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (cfg_o == $past(wdata_i)));

endmodule

// File: rtl/tft_frame_ctr.sv
`timescale 1ns/1ps
module tft_frame_ctr #(
    parameter int SUBFRAMES = 7,
    parameter int BLOCKS    = 8,
    parameter int BLK_PAY   = 84,
    parameter int E3_LEN    = 1536,
    parameter int E3_OH     = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic e3_i,
    input  logic sync_i,
    output logic pay_o,
    output logic ohen_o,
    output logic sof_o
);

    localparam int BLK_LEN      = BLK_PAY + 1;
    localparam int DS3_LEN      = SUBFRAMES * BLOCKS * BLK_LEN;
    localparam int MAX_LEN      = (DS3_LEN > E3_LEN) ? DS3_LEN : E3_LEN;
    localparam int POS_W        = $clog2(MAX_LEN);
    localparam int BLK_W        = $clog2(BLK_LEN);
    localparam int DS3_LAST     = DS3_LEN - 1;
    localparam int E3_LAST      = E3_LEN - 1;
    localparam int DS3_LAST_BLK = DS3_LAST % BLK_LEN;
    localparam int E3_LAST_BLK  = E3_LAST % BLK_LEN;

    // blk tracks pos modulo the block length at all times.
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [BLK_W-1:0] blk;
        logic             pay;
        logic             ohen;
        logic             sof;
    } st_t;

    st_t st_d, st_q;
    logic [POS_W-1:0] last_pos;

    always_comb begin
        last_pos = e3_i ? POS_W'(E3_LAST) : POS_W'(DS3_LAST);
        st_d     = st_q;
        if (sync_i) begin
            st_d.pos = last_pos;
            st_d.blk = e3_i ? BLK_W'(E3_LAST_BLK) : BLK_W'(DS3_LAST_BLK);
        end else if (st_q.pos >= last_pos) begin
            st_d.pos = '0;
            st_d.blk = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
            st_d.blk = (st_q.blk == BLK_W'(BLK_LEN - 1)) ? '0 : st_q.blk + 1'b1;
        end
        st_d.pay  = e3_i ? (st_d.pos >= POS_W'(E3_OH)) : (st_d.blk != '0);
        st_d.ohen = ~st_d.pay;
        st_d.sof  = (st_d.pos == last_pos);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.ohen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pay_o  = st_q.pay;
    assign ohen_o = st_q.ohen;
    assign sof_o  = st_q.sof;

    // R3: the position never leaves the longest frame
    a_r3_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pos <= POS_W'(DS3_LAST));

    // R5: a frame mark lasts one bit time unless a resync holds it
    a_r5_sof_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_o && !sync_i) |=> !sof_o);

    // R6: a resync lands on the last bit of the frame
    a_r6_sync_to_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> sof_o);

    // R3: the bit after the frame mark is overhead in both framings
    a_r3_wrap_overhead: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_o && !sync_i) |=> (!pay_o && ohen_o));

endmodule

// File: rtl/tft_pin_pol.sv
`timescale 1ns/1ps
module tft_pin_pol #(
    parameter int N = 1
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] inv_i,
    output logic [N-1:0] fix_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign fix_o[g] = inv_i[g] ? ~raw_i[g] : raw_i[g];
    end

endmodule

// File: rtl/tft_qual_gen.sv
`timescale 1ns/1ps
module tft_qual_gen (
    input  logic clk_i,
    input  logic pay_i,
    input  logic gap_mode_i,
    input  logic force_i,
    output logic qual_o
);

    logic pay_lat;
    logic gclk;

    // Transparent while the clock is low, so the gate is stable in the high phase.
    always_latch begin
        if (!clk_i) begin
            pay_lat <= pay_i;
        end
    end

    assign gclk = clk_i & pay_lat;

    always_comb begin
        if (force_i) begin
            qual_o = clk_i;
        end else if (gap_mode_i) begin
            qual_o = gclk;
        end else begin
            qual_o = pay_i;
        end
    end

endmodule

// File: rtl/tx_frame_timer.sv
`timescale 1ns/1ps
module tx_frame_timer
    import tft_pkg::*;
(
    input  logic       clk_pin,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       clk_force,
    input  logic       e3_sel,
    input  logic       sof_pin_in,
    output logic       sof_pin_out,
    output logic       sof_pin_oe,
    input  logic       data_pin,
    output logic       data_core,
    input  logic       oh_pin,
    output logic       oh_core,
    output logic       ohen_pin,
    output logic       qual_pin
);

    cfg_t cfg;
    logic clk_core;
    logic sof_in_fix;
    logic sync;
    logic pay_lvl, ohen_lvl, sof_lvl;
    logic qual_raw;

    tft_cfg_reg u_cfg (
        .clk_i   (clk_pin),
        .rst_ni  (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_t'(cfg_wdata)),
        .cfg_o   (cfg)
    );

    assign cfg_rdata  = cfg;
    assign clk_core   = clk_pin ^ cfg.clk_inv;
    assign sof_pin_oe = cfg.sof_dir;

    tft_pin_pol #(.N(3)) u_in_pol (
        .raw_i ({sof_pin_in, oh_pin, data_pin}),
        .inv_i ({cfg.sof_inv, cfg.oh_inv, cfg.data_inv}),
        .fix_o ({sof_in_fix, oh_core, data_core})
    );

    // R12: the input side only steers the counter while the pin is an input
    assign sync = sof_in_fix & ~cfg.sof_dir;

    tft_frame_ctr u_ctr (
        .clk_i  (clk_core),
        .rst_ni (rst_n),
        .e3_i   (e3_sel),
        .sync_i (sync),
        .pay_o  (pay_lvl),
        .ohen_o (ohen_lvl),
        .sof_o  (sof_lvl)
    );

    tft_qual_gen u_qual (
        .clk_i      (clk_core),
        .pay_i      (pay_lvl),
        .gap_mode_i (cfg.qmode),
        .force_i    (clk_force),
        .qual_o     (qual_raw)
    );

    tft_pin_pol #(.N(3)) u_out_pol (
        .raw_i ({sof_lvl, ohen_lvl, qual_raw}),
        .inv_i ({cfg.sof_inv, cfg.ohen_inv, cfg.qual_inv}),
        .fix_o ({sof_pin_out, ohen_pin, qual_pin})
    );

    // R7: the counter's payload and overhead-enable levels are never equal
    a_r7_ohen_complement: assert property (@(posedge clk_core) disable iff (!rst_n)
        ohen_lvl != pay_lvl);

endmodule

// File: tb/tx_frame_timer_tb_top.sv
`timescale 1ns/1ps
module tx_frame_timer_tb_top;

    localparam int DS3_N = 4760;
    localparam int E3_N  = 1536;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       clk_force;
    logic       e3_sel;
    logic       sof_pin_in;
    logic       sof_pin_out;
    logic       sof_pin_oe;
    logic       data_pin;
    logic       data_core;
    logic       oh_pin;
    logic       oh_core;
    logic       ohen_pin;
    logic       qual_pin;

    int total = 0;
    int bad   = 0;
    logic [7:0] cfg_sh = 8'h00;
    bit         e3_sh  = 1'b0;

    typedef struct {
        logic  qual;
        logic  ohen;
        logic  sof;
        bit    chk_sof;
        int    pos;
        string req;
    } exp_t;

    exp_t sbq[$];
    bit   sb_on = 1'b0;

    always #2.5 clk = ~clk;

    tx_frame_timer dut_i (
        .clk_pin     (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .clk_force   (clk_force),
        .e3_sel      (e3_sel),
        .sof_pin_in  (sof_pin_in),
        .sof_pin_out (sof_pin_out),
        .sof_pin_oe  (sof_pin_oe),
        .data_pin    (data_pin),
        .data_core   (data_core),
        .oh_pin      (oh_pin),
        .oh_core     (oh_core),
        .ohen_pin    (ohen_pin),
        .qual_pin    (qual_pin)
    );

    function automatic bit pay_of(int p, bit e3);
        if (e3) return (p >= 12);
        return ((p % 85) != 0);
    endfunction

    function automatic int flen(bit e3);
        return e3 ? E3_N : DS3_N;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_frame(int start, int n, string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int   p;
            p         = (start + i) % flen(e3_sh);
            e.pos     = p;
            e.qual    = pay_of(p, e3_sh) ^ cfg_sh[0];
            e.ohen    = (~pay_of(p, e3_sh)) ^ cfg_sh[5];
            e.sof     = (p == flen(e3_sh) - 1) ^ cfg_sh[3];
            e.chk_sof = cfg_sh[6];
            e.req     = req;
            sbq.push_back(e);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (sb_on && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk($sformatf("%s qual pos=%0d", e.req, e.pos), qual_pin, e.qual);
            chk($sformatf("%s R7 ohen pos=%0d", e.req, e.pos), ohen_pin, e.ohen);
            if (e.chk_sof)
                chk($sformatf("%s R5 sof pos=%0d", e.req, e.pos), sof_pin_out, e.sof);
        end
    end

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_sh    = v;
    endtask

    task automatic wait_sof();
        do @(negedge clk); while ((sof_pin_out ^ cfg_sh[3]) !== 1'b1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_wdata  = 8'h00;
        clk_force  = 1'b0;
        e3_sel     = 1'b0;
        sof_pin_in = 1'b0;
        data_pin   = 1'b0;
        oh_pin     = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cfg", cfg_rdata, 8'h00);
        chk("R1 oe", sof_pin_oe, 1'b0);
        chk("R1 qual", qual_pin, 1'b0);
        chk("R1 ohen", ohen_pin, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg after release", cfg_rdata, 8'h00);

        // R2: register load and read-back
        wr_cfg(8'hA5);
        chk("R2 readback A5", cfg_rdata, 8'hA5);
        wr_cfg(8'h40);
        chk("R2 readback 40", cfg_rdata, 8'h40);
        chk("R5 oe", sof_pin_oe, 1'b1);

        // R3 and R5 over a full DS3 frame, with R12 input pulses mixed in
        sb_on = 1'b1;
        wait_sof();
        #1;
        push_frame(0, DS3_N + 2, "R3 R12");
        repeat (100) @(negedge clk);
        #1 sof_pin_in = 1'b1;
        @(negedge clk);
        #1 sof_pin_in = 1'b0;
        drain();

        // R4: E3 framing
        @(negedge clk);
        e3_sel = 1'b1;
        e3_sh  = 1'b1;
        wait_sof();
        #1;
        push_frame(0, E3_N + 2, "R4");
        drain();

        // R10: output pin inversions
        wr_cfg(8'h69);
        wait_sof();
        #1;
        push_frame(0, 300, "R10");
        drain();

        // R10: data and overhead data inversion
        wr_cfg(8'h52);
        data_pin = 1'b1;
        oh_pin   = 1'b0;
        #1;
        chk("R10 data inverted", data_core, 1'b0);
        chk("R10 oh inverted", oh_core, 1'b1);
        wr_cfg(8'h40);
        #1;
        chk("R10 data straight", data_core, 1'b1);
        chk("R10 oh straight", oh_core, 1'b0);

        // R6: resync through the input, DS3 framing
        @(negedge clk);
        e3_sel = 1'b0;
        e3_sh  = 1'b0;
        wr_cfg(8'h00);
        chk("R6 oe", sof_pin_oe, 1'b0);
        repeat (1000) @(negedge clk);
        #1 sof_pin_in = 1'b1;
        push_frame(DS3_N - 1, 200, "R6");
        @(negedge clk);
        #1 sof_pin_in = 1'b0;
        drain();

        // R6 with input inversion: idle high, active low
        wr_cfg(8'h08);
        sof_pin_in = 1'b1;
        repeat (333) @(negedge clk);
        #1 sof_pin_in = 1'b0;
        push_frame(DS3_N - 1, 200, "R6 inv");
        @(negedge clk);
        #1 sof_pin_in = 1'b1;
        drain();
        sb_on = 1'b0;
        sof_pin_in = 1'b0;

        // R8: gapped clock
        wr_cfg(8'hC0);
        wait_sof();
        for (int i = 0; i < 200; i++) begin
            int ended;
            ended = (i == 0) ? DS3_N - 1 : i - 1;
            @(posedge clk);
            #1 chk($sformatf("R8 high phase bit=%0d", ended), qual_pin, pay_of(ended, 1'b0));
            @(negedge clk);
            #1 chk("R8 low phase", qual_pin, 1'b0);
        end

        // R9: override beats the mode bit, polarity still applies
        clk_force = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1 chk("R9 gap mode high", qual_pin, 1'b1);
            @(negedge clk);
            #1 chk("R9 gap mode low", qual_pin, 1'b0);
        end
        wr_cfg(8'h41);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1 chk("R9 level mode inverted high", qual_pin, 1'b0);
            @(negedge clk);
            #1 chk("R9 level mode inverted low", qual_pin, 1'b1);
        end
        clk_force = 1'b0;

        // R11: clock inversion moves timing to the falling pin edge
        wr_cfg(8'h44);
        begin
            realtime t1, t2;
            @(posedge sof_pin_out);
            #0.1 chk("R11 clock phase at mark", clk, 1'b0);
            @(posedge sof_pin_out);
            t1 = $realtime;
            #0.1 chk("R11 clock phase at mark 2", clk, 1'b0);
            @(posedge sof_pin_out);
            t2 = $realtime;
            chk("R11 frame period", int'((t2 - t1) / 5.0), DS3_N);
        end

        finish_run();
    end

endmodule